// File: doc/BRIEF.md
# SPI Command Instruction Sequencer

This block is an SPI bus master that is programmed by a stream of 16-bit instruction words instead of a fixed set of control registers. A host (a processor front-end or a small DMA) pushes instructions through a ready/valid command port. Each instruction does one job: it moves a run of bytes over the bus, it updates the chip-select lines and can hold the bus for a short time afterwards, it writes one of two internal settings (the SCLK divider and the clock mode), it sleeps for a programmed time, or it emits a numbered sync marker.

Bytes to be sent arrive on a ready/valid transmit stream. Bytes read from the bus leave on a ready/valid receive stream. The engine takes one instruction at a time and finishes it before it accepts the next. A sync marker therefore tells the host that every instruction queued before it has fully finished on the wire. The SCLK half-period is (divider+1) reference clocks. Data moves most significant bit first, in any of the four CPOL/CPHA modes.

Top module: `spi_cmd_sequencer`

## Requirements
- R1: While reset is asserted and after it is released: cs_n is all ones, sclk is 0, mosi is 0, cmd_ready is 1, rx_valid is 0 and sync_valid is 0.
- R2: An instruction word carries the opcode in bits 13:12, argument A in bits 11:8 and argument B in bits 7:0. The opcodes are 0 transfer, 1 chip-select, 2 setting write and 3 miscellaneous. Bits 15:14 must be zero.
- R3: Opcode 1 loads B[CS_W-1:0] onto cs_n at the edge that accepts it. cmd_ready then stays low for A×(divider+1) cycles, and for no cycles when A is 0.
- R4: Opcode 2 with A=0 loads B into the divider. An SCLK half-period lasts divider+1 clock cycles, so a word keeps sclk away from its idle level for 8×(divider+1) cycles.
- R5: Opcode 2 with A=1 loads B[0] as CPHA and B[1] as CPOL (B[2] is accepted and has no effect). sclk rests at CPOL whenever no word is being shifted.
- R6: Opcode 0 moves B+1 words of WORD_W bits, MSB first, with WORD_W sampling edges per word. mosi is stable at each slave sampling edge: the leading edge when CPHA=0 and the trailing edge when CPHA=1. The engine samples miso on the same edge.
- R7: Flag A[0] makes each word take one transmit byte; without it no byte is taken and mosi stays 0. Flag A[1] makes each received word appear on rx_data/rx_valid; without it no receive word is produced.
- R8: A word does not start, and sclk stays at its idle level, while a needed transmit byte is missing or while a received word is still waiting in the receive output.
- R9: Opcode 3 with A=1 keeps cmd_ready low for 2×(B+1)×(divider+1) cycles.
- R10: Opcode 3 with A=0 raises sync_valid for exactly the one cycle after its acceptance, with sync_id equal to B. All earlier instructions have finished by then.
- R11: These combinations are consumed as no-ops, with no change to cs_n, to the settings, to the streams or to sync, and with cmd_ready high again on the next cycle: bits 15:14 nonzero, a setting write with A>1, opcode 3 with A>1, and a transfer with A[3:2] nonzero.
- R12: While rx_valid is high and rx_ready is low, rx_valid stays high and rx_data does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Instruction word offered |
| cmd_ready | output | 1 | Engine accepts an instruction |
| cmd_data | input | 16 | Instruction word |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Engine takes a transmit byte |
| tx_data | input | WORD_W | Transmit byte |
| rx_valid | output | 1 | Received word held |
| rx_ready | input | 1 | Consumer takes the received word |
| rx_data | output | WORD_W | Received word |
| cs_n | output | CS_W | Active-low chip selects |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| sync_valid | output | 1 | One-cycle sync marker |
| sync_id | output | 8 | Identifier of the last sync marker |

## Verification
The transfer path is swept over all four clock modes, each at dividers 0, 1 and 3. The bench loops mosi back to miso, inverted in some runs. Comparing captured mosi words with the received words separates bit order from sampling edge. Counting the cycles sclk spends off its idle level separates divider errors from phase errors. Further runs use write-only and read-only flag patterns, starve the transmit stream and block the receive stream, and measure cmd_ready low time after sleeps and chip-select delays. Each no-op encoding is sent and then probed through a later sleep, cs_n and the streams.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

   localparam int CMD_W = 16;

   typedef enum logic [1:0] {
      OP_XFER  = 2'd0,
      OP_CS    = 2'd1,
      OP_SETWR = 2'd2,
      OP_MISC  = 2'd3
   } op_e;

   // instruction word layout, MSB first
   typedef struct packed {
      logic [1:0] rsvd;
      op_e        op;
      logic [3:0] a;
      logic [7:0] b;
   } cmd_t;

   typedef enum logic [1:0] {
      ST_FETCH = 2'd0,
      ST_XFER  = 2'd1,
      ST_WAIT  = 2'd2
   } st_e;

   localparam logic [3:0] SET_DIV    = 4'd0;
   localparam logic [3:0] SET_MODE   = 4'd1;
   localparam logic [3:0] MISC_SYNC  = 4'd0;
   localparam logic [3:0] MISC_SLEEP = 4'd1;

   localparam int WAIT_W = 10;

endpackage

// File: rtl/seq_halfbit_timer.sv
module seq_halfbit_timer #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt;

   assign tick = en && (cnt == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!en || tick)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (cnt <= div)); // R4

endmodule

// File: rtl/seq_word_shifter.sv
module seq_word_shifter #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] tx_word,
   input  logic              tick,
   input  logic              miso_s,
   input  logic              cpol,
   input  logic              cpha,
   output logic              active,
   output logic              last,
   output logic [WORD_W-1:0] rx_word,
   output logic              mosi_bit,
   output logic              sclk_lvl
);

   localparam int HALF_N = 2 * WORD_W;
   localparam int HW     = $clog2(HALF_N);
   localparam logic [HW-1:0] H_LAST = HW'(HALF_N - 1);

   logic [HW-1:0]     h;
   logic [WORD_W-1:0] tsh;
   logic [WORD_W-1:0] rsh;

   assign last = active && tick && (h == H_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         h      <= '0;
         tsh    <= '0;
         rsh    <= '0;
      end else if (start) begin
         active <= 1'b1;
         h      <= '0;
         tsh    <= tx_word;
      end else if (active && tick) begin
         if (!h[0])
            rsh <= {rsh[WORD_W-2:0], miso_s};
         else if (!last)
            tsh <= {tsh[WORD_W-2:0], 1'b0};
         if (last) begin
            active <= 1'b0;
            h      <= '0;
         end else begin
            h <= h + 1'b1;
         end
      end
   end

   assign rx_word  = rsh;
   assign mosi_bit = active ? tsh[WORD_W-1] : 1'b0;
   assign sclk_lvl = active ? (cpol ^ cpha ^ h[0]) : cpol;

   AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !active); // R8

endmodule

// File: rtl/spi_cmd_sequencer.sv
module spi_cmd_sequencer
   import spi_seq_pkg::*;
#(
   parameter int WORD_W    = 8,
   parameter int CS_W      = 8,
   parameter int DIV_W     = 8,
   parameter int MISO_SYNC = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [CMD_W-1:0]  cmd_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   input  logic [WORD_W-1:0] tx_data,
   output logic              rx_valid,
   input  logic              rx_ready,
   output logic [WORD_W-1:0] rx_data,
   output logic [CS_W-1:0]   cs_n,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic              sync_valid,
   output logic [7:0]        sync_id
);

   if (WORD_W < 2) begin : g_bad_word
      $error("WORD_W must be at least 2");
   end
   if (CS_W < 1 || CS_W > 8) begin : g_bad_cs
      $error("CS_W must lie in 1..8");
   end
   if (DIV_W < 1 || DIV_W > 8) begin : g_bad_div
      $error("DIV_W must lie in 1..8");
   end
   if (MISO_SYNC < 0) begin : g_bad_sync
      $error("MISO_SYNC must not be negative");
   end

   // serial input conditioning
   logic miso_s;
   if (MISO_SYNC == 0) begin : g_miso_direct
      assign miso_s = miso;
   end else begin : g_miso_sync
      logic [MISO_SYNC-1:0] ff;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ff <= '0;
         else
            ff <= (ff << 1) | MISO_SYNC'(miso);
      end
      assign miso_s = ff[MISO_SYNC-1];
   end

   st_e               st;
   logic [DIV_W-1:0]  div_q;
   logic              cpol_q;
   logic              cpha_q;
   logic [CS_W-1:0]   cs_q;
   logic [WAIT_W-1:0] left_q;
   logic [7:0]        words_q;
   logic              wr_q;
   logic              rd_q;
   logic              rxv_q;
   logic [WORD_W-1:0] rxd_q;
   logic              syncv_q;
   logic [7:0]        syncid_q;

   // instruction decode
   cmd_t c;
   logic acc, legal;
   logic do_xfer, do_cs, do_div, do_mode, do_sync, do_sleep;

   assign c         = cmd_t'(cmd_data);
   assign cmd_ready = (st == ST_FETCH);
   assign acc       = cmd_valid && cmd_ready;
   assign legal     = acc && (c.rsvd == 2'b00);
   assign do_xfer   = legal && (c.op == OP_XFER) && (c.a[3:2] == 2'b00);
   assign do_cs     = legal && (c.op == OP_CS);
   assign do_div    = legal && (c.op == OP_SETWR) && (c.a == SET_DIV);
   assign do_mode   = legal && (c.op == OP_SETWR) && (c.a == SET_MODE);
   assign do_sync   = legal && (c.op == OP_MISC)  && (c.a == MISC_SYNC);
   assign do_sleep  = legal && (c.op == OP_MISC)  && (c.a == MISC_SLEEP);

   // timing and shifting
   logic              tick, tmr_en;
   logic              sh_active, sh_last, sh_mosi, sh_sclk, sh_start;
   logic [WORD_W-1:0] sh_rx, sh_tx;
   logic              can_go;

   assign can_go   = (st == ST_XFER) && !sh_active && (!rd_q || !rxv_q);
   assign tx_ready = can_go && wr_q;
   assign sh_start = can_go && (!wr_q || tx_valid);
   assign sh_tx    = wr_q ? tx_data : '0;
   assign tmr_en   = (st == ST_WAIT) || sh_active;

   seq_halfbit_timer #(.DIV_W(DIV_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (tmr_en),
      .div   (div_q),
      .tick  (tick)
   );

   seq_word_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (sh_start),
      .tx_word  (sh_tx),
      .tick     (tick),
      .miso_s   (miso_s),
      .cpol     (cpol_q),
      .cpha     (cpha_q),
      .active   (sh_active),
      .last     (sh_last),
      .rx_word  (sh_rx),
      .mosi_bit (sh_mosi),
      .sclk_lvl (sh_sclk)
   );

   // sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_FETCH;
         div_q   <= '0;
         cpol_q  <= 1'b0;
         cpha_q  <= 1'b0;
         cs_q    <= '1;
         left_q  <= '0;
         words_q <= '0;
         wr_q    <= 1'b0;
         rd_q    <= 1'b0;
      end else begin
         case (st)
            ST_FETCH: begin
               if (do_xfer) begin
                  st      <= ST_XFER;
                  words_q <= c.b;
                  wr_q    <= c.a[0];
                  rd_q    <= c.a[1];
               end
               if (do_cs) begin
                  cs_q <= c.b[CS_W-1:0];
                  if (c.a != 4'd0) begin
                     st     <= ST_WAIT;
                     left_q <= WAIT_W'(c.a);
                  end
               end
               if (do_div)
                  div_q <= c.b[DIV_W-1:0];
               if (do_mode) begin
                  cpha_q <= c.b[0];
                  cpol_q <= c.b[1];
               end
               if (do_sleep) begin
                  st     <= ST_WAIT;
                  left_q <= (WAIT_W'(c.b) + WAIT_W'(1)) << 1;
               end
            end
            ST_WAIT: begin
               if (tick) begin
                  left_q <= left_q - 1'b1;
                  if (left_q == WAIT_W'(1))
                     st <= ST_FETCH;
               end
            end
            ST_XFER: begin
               if (sh_last) begin
                  if (words_q == 8'd0)
                     st <= ST_FETCH;
                  else
                     words_q <= words_q - 1'b1;
               end
            end
            default: st <= ST_FETCH;
         endcase
      end
   end

   // receive output slot
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rxv_q <= 1'b0;
         rxd_q <= '0;
      end else if (sh_last && rd_q) begin
         rxv_q <= 1'b1;
         rxd_q <= sh_rx;
      end else if (rx_ready) begin
         rxv_q <= 1'b0;
      end
   end

   // sync marker
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         syncv_q  <= 1'b0;
         syncid_q <= '0;
      end else begin
         syncv_q <= do_sync;
         if (do_sync)
            syncid_q <= c.b;
      end
   end

   assign rx_valid   = rxv_q;
   assign rx_data    = rxd_q;
   assign cs_n       = cs_q;
   assign sclk       = sh_sclk;
   assign mosi       = sh_mosi;
   assign sync_valid = syncv_q;
   assign sync_id    = syncid_q;

   AST_CS_ONLY_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      !do_cs |=> $stable(cs_n)); // R3
   AST_IDLE_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FETCH) |-> (sclk == cpol_q)); // R5
   AST_RX_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_valid) |-> $past(rd_q)); // R7
   AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT) |-> !sh_active); // R9
   AST_SYNC_AFTER_WORK: assert property (@(posedge clk) disable iff (!rst_n)
      sync_valid |-> ((st == ST_FETCH) && !sh_active)); // R10
   AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))); // R12

endmodule

// File: tb/tb_spi_cmd_sequencer.sv
module tb_spi_cmd_sequencer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [15:0] cmd_data = '0;
   logic        cmd_ready;
   logic        tx_valid = 1'b0;
   logic [7:0]  tx_data = '0;
   logic        tx_ready;
   logic        rx_valid;
   logic        rx_ready = 1'b0;
   logic [7:0]  rx_data;
   logic [7:0]  cs_n;
   logic        sclk, mosi, miso;
   logic        sync_valid;
   logic [7:0]  sync_id;
   logic        miso_inv = 1'b0;

   always #5 clk = ~clk;
   assign miso = mosi ^ miso_inv;

   spi_cmd_sequencer dut (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
      .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
      .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso),
      .sync_valid(sync_valid), .sync_id(sync_id)
   );

   int n_checks = 0;
   int n_err = 0;
   bit done = 1'b0;
   int run_id = 0;
   logic cur_cpol = 1'b0;
   logic cur_cpha = 1'b0;

   logic [7:0] tx_mem [16];
   int  tx_cnt = 0;
   bit  tx_on = 1'b0;
   int  tx_taken = 0;
   logic [7:0] rx_mem [16];
   int  rx_n = 0;
   bit  rx_hold = 1'b0;
   logic [7:0] mon_mem [16];
   logic [7:0] mon_sh = '0;
   int  mon_edges = 0, mon_words = 0, mon_act = 0;
   int  sync_cnt = 0;
   logic [7:0] sync_last = '0;

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // R2: opcode 13:12, argument A 11:8, argument B 7:0
   function automatic logic [15:0] mk(input int op, input int a, input int b);
      return {2'b00, 2'(op), 4'(a), 8'(b)};
   endfunction

   task automatic send(input logic [15:0] w);
      cmd_valid = 1'b1;
      cmd_data  = w;
      while (!cmd_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic low_cycles(output int n);
      n = 0;
      while (!cmd_ready) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic setup(input int pol, input int pha, input int dv);
      send(mk(2, 1, pol * 2 + pha));
      send(mk(2, 0, dv));
      cur_cpol = 1'(pol);
      cur_cpha = 1'(pha);
      repeat (2) @(negedge clk);
      run_id++;
      @(negedge clk);
   endtask

   task automatic wait_sync(input int target);
      while (sync_cnt < target) @(negedge clk);
      repeat (6) @(negedge clk);
   endtask

   // transmit source
   initial begin
      int my_run = 0;
      bit pend = 1'b0;
      forever begin
         @(negedge clk);
         if (run_id != my_run) begin
            my_run = run_id;
            tx_taken = 0;
            pend = 1'b0;
         end else if (pend) begin
            tx_taken++;
         end
         tx_valid = tx_on && (tx_taken < tx_cnt);
         tx_data  = tx_mem[tx_taken % 16];
         pend     = tx_valid && tx_ready;
      end
   end

   // receive sink
   initial begin
      int my_run = 0;
      int ph = 0;
      bit pend = 1'b0;
      logic [7:0] cap = '0;
      forever begin
         @(negedge clk);
         if (run_id != my_run) begin
            my_run = run_id;
            rx_n = 0;
            pend = 1'b0;
         end else if (pend) begin
            rx_mem[rx_n % 16] = cap;
            rx_n++;
         end
         ph = (ph + 1) % 3;
         rx_ready = !rx_hold && (ph != 2);
         cap  = rx_data;
         pend = rx_valid && rx_ready;
      end
   end

   // bus monitor
   initial begin
      int my_run = 0;
      logic prev = 1'b0;
      forever begin
         @(negedge clk);
         if (run_id != my_run) begin
            my_run = run_id;
            mon_edges = 0; mon_words = 0; mon_act = 0; sync_cnt = 0;
            prev = sclk;
         end else begin
            if (sclk != cur_cpol) mon_act++;
            if (sclk != prev && ((!cur_cpha && sclk != cur_cpol) || (cur_cpha && sclk == cur_cpol))) begin
               mon_sh = {mon_sh[6:0], mosi};
               mon_edges++;
               if (mon_edges % 8 == 0) begin
                  mon_mem[mon_words % 16] = mon_sh;
                  mon_words++;
               end
            end
            prev = sclk;
            if (sync_valid) begin
               sync_cnt++;
               sync_last = sync_id;
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", n_checks + 1, n_err + 1);
         $finish;
      end
   end

   task automatic run_words(input int n, input int flags, input int base, input int id);
      for (int i = 0; i < n; i++) tx_mem[i] = 8'(base + i * 37);
      tx_cnt = n;
      tx_on  = 1'b1;
      send(mk(1, 0, 8'hFE));
      send(mk(0, flags, n - 1));
      send(mk(1, 0, 8'hFF));
      send(mk(3, 0, id));
      wait_sync(1);
   endtask

   initial begin
      int lo;
      logic [7:0] d0;
      repeat (3) @(negedge clk);
      chk("R1", "cs_n in reset", int'(cs_n), 255);
      chk("R1", "sclk in reset", int'(sclk), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "cs_n", int'(cs_n), 255);
      chk("R1", "mosi", int'(mosi), 0);
      chk("R1", "cmd_ready", int'(cmd_ready), 1);
      chk("R1", "rx_valid", int'(rx_valid), 0);
      chk("R1", "sync_valid", int'(sync_valid), 0);

      // mode and divider sweep, full duplex, loopback
      for (int pol = 0; pol < 2; pol++)
         for (int pha = 0; pha < 2; pha++)
            for (int k = 0; k < 3; k++) begin
               int dv;
               int inv;
               dv  = (k == 2) ? 3 : k;
               inv = (pol + k) % 2;
               miso_inv = 1'(inv);
               setup(pol, pha, dv);
               run_words(3, 3, pol * 40 + pha * 11 + k * 5 + 1, run_id);
               chk("R7", "tx bytes taken", tx_taken, 3);
               chk("R7", "rx words", rx_n, 3);
               for (int i = 0; i < 3; i++) begin
                  chk("R6", "rx word", int'(rx_mem[i]), int'(tx_mem[i] ^ {8{1'(inv)}}));
                  chk("R6", "mosi word MSB first", int'(mon_mem[i]), int'(tx_mem[i]));
               end
               chk("R6", "sampling edges", mon_edges, 24);
               chk("R4", "sclk active cycles", mon_act, 24 * (dv + 1));
               chk("R5", "sclk idle level", int'(sclk), pol);
               chk("R10", "sync id", int'(sync_last), run_id % 256);
               chk("R10", "sync pulses", sync_cnt, 1);
               chk("R3", "cs_n released", int'(cs_n), 255);
            end

      // write only
      miso_inv = 1'b1;
      setup(0, 0, 1);
      run_words(2, 1, 90, 7);
      chk("R7", "write-only tx taken", tx_taken, 2);
      chk("R7", "write-only rx words", rx_n, 0);
      chk("R6", "write-only mosi word", int'(mon_mem[1]), int'(tx_mem[1]));

      // read only
      setup(1, 1, 0);
      run_words(2, 2, 20, 8);
      chk("R7", "read-only tx taken", tx_taken, 0);
      chk("R7", "read-only rx words", rx_n, 2);
      chk("R7", "read-only rx value", int'(rx_mem[0]), 255);
      chk("R7", "read-only mosi zero", int'(mon_mem[1]), 0);

      // transmit starvation
      miso_inv = 1'b0;
      setup(0, 0, 1);
      tx_on = 1'b0;
      tx_mem[0] = 8'h3C; tx_mem[1] = 8'hC3; tx_cnt = 2;
      send(mk(0, 1, 1));
      repeat (40) @(negedge clk);
      chk("R8", "no sclk without tx byte", mon_act, 0);
      chk("R8", "no tx taken while stalled", tx_taken, 0);
      tx_on = 1'b1;
      send(mk(3, 0, 9));
      wait_sync(1);
      chk("R8", "tx taken after release", tx_taken, 2);
      chk("R8", "active cycles after release", mon_act, 32);

      // receive back-pressure
      setup(0, 1, 0);
      rx_hold = 1'b1;
      tx_mem[0] = 8'h96; tx_mem[1] = 8'h5A; tx_cnt = 2; tx_on = 1'b1;
      send(mk(0, 3, 1));
      repeat (60) @(negedge clk);
      chk("R8", "second word held back", mon_act, 8);
      chk("R12", "rx_valid held", int'(rx_valid), 1);
      d0 = rx_data;
      repeat (5) @(negedge clk);
      chk("R12", "rx_data stable", int'(rx_data), int'(d0));
      chk("R12", "rx_data value", int'(d0), 8'h96);
      rx_hold = 1'b0;
      send(mk(3, 0, 10));
      wait_sync(1);
      chk("R8", "rx words after release", rx_n, 2);
      chk("R8", "second rx word", int'(rx_mem[1]), 8'h5A);

      // sleep timing
      setup(0, 0, 2);
      send(mk(3, 1, 4));
      low_cycles(lo);
      chk("R9", "sleep 5 units div 2", lo, 30);
      setup(0, 0, 0);
      send(mk(3, 1, 0));
      low_cycles(lo);
      chk("R9", "sleep 1 unit div 0", lo, 2);

      // chip-select delay
      setup(0, 0, 1);
      send(mk(1, 3, 8'hA5));
      chk("R3", "cs_n loaded", int'(cs_n), 8'hA5);
      low_cycles(lo);
      chk("R3", "cs delay cycles", lo, 6);
      send(mk(1, 0, 8'hFF));
      low_cycles(lo);
      chk("R3", "no delay", lo, 0);
      chk("R3", "cs_n released", int'(cs_n), 255);

      // sync follows earlier work
      send(mk(3, 1, 2));
      send(mk(3, 0, 8'h5A));
      chk("R10", "sync pulse after accept", int'(sync_valid), 1);
      chk("R10", "sync id value", int'(sync_id), 8'h5A);
      @(negedge clk);
      chk("R10", "pulse one cycle", int'(sync_valid), 0);

      // no-op encodings (div is 1)
      run_id++;
      @(negedge clk);
      send(16'hD000);
      low_cycles(lo);
      chk("R11", "reserved bits ready", lo, 0);
      chk("R11", "reserved bits cs_n", int'(cs_n), 255);
      send(mk(2, 5, 9));
      low_cycles(lo);
      chk("R11", "bad target ready", lo, 0);
      send(mk(3, 1, 0));
      low_cycles(lo);
      chk("R11", "divider kept", lo, 4);
      send(mk(3, 2, 7));
      low_cycles(lo);
      chk("R11", "bad misc ready", lo, 0);
      tx_mem[0] = 8'h11; tx_cnt = 1; tx_on = 1'b1;
      send(mk(0, 4, 0));
      low_cycles(lo);
      chk("R11", "bad flags ready", lo, 0);
      repeat (20) @(negedge clk);
      chk("R11", "bad flags no tx", tx_taken, 0);
      chk("R11", "bad flags no sclk", mon_act, 0);
      chk("R11", "no sync", sync_cnt, 0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
   end

endmodule